// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block divides the system clock by a 16-bit ratio held in two byte-wide divisor latches, a low byte and a high byte, and emits a one-cycle tick each time the ratio elapses. A serial transmitter or receiver uses the tick as its bit-rate enable. A processor writes the latches through a small byte-addressed register port.

The low-byte latch shares its address with the serial data registers: the receive buffer on reads and the transmit holding register on writes. A latch-select bit, taken from the line control register that sits outside this block, steers that address. When the bit is 1, accesses at the address reach the divisor latch. When it is 0, they are passed to the data path through a write strobe, a read strobe and a read-data input. The high-byte latch is at the next address. It is reachable only while the select bit is 1; otherwise that address belongs to a register elsewhere.

Any write to a latch byte reloads the whole divisor into the running counter, so the next tick is timed from that write. Ratios of 0 and 1 have no defined meaning, and the block runs them as a ratio of 2.

Top module: `baud_rate_gen`

## Requirements
- R1: With latch_sel_i = 1, a write at address 0 sets the low byte and a write at address 1 sets the high byte. divisor_o is {high, low}, and a read at either address returns that byte unchanged on rdata_o in the same cycle.
- R2: After reset, divisor_o is 0x0002 and tick_o pulses every 2 cycles, first in the cycle after the first rising edge.
- R3: For a divisor N from 0x0002 to 0xFFFF, tick_o is high for exactly one cycle out of every N cycles.
- R4: A write to either latch byte restarts the count. tick_o is high in the N-th cycle after the edge that captures the write, where N is the new divisor, and then every N cycles.
- R5: A stored divisor of 0x0000 or 0x0001 reads back as written but produces a tick every 2 cycles.
- R6: With latch_sel_i = 0 at address 0, a write raises data_we_o and leaves divisor_o unchanged. A read raises data_re_o and returns data_rdata_i on rdata_o.
- R7: With latch_sel_i = 0 at address 1, or at any address other than 0 and 1, writes change neither divisor_o nor data_we_o. rdata_o reads 0 there and whenever re_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| latch_sel_i | input | 1 | Divisor latch access bit from line control |
| data_rdata_i | input | 8 | Receive buffer byte from the data path |
| rdata_o | output | 8 | Read data |
| data_we_o | output | 1 | Write strobe to the transmit holding register |
| data_re_o | output | 1 | Read strobe to the receive buffer |
| tick_o | output | 1 | One-cycle baud tick |
| divisor_o | output | 16 | Current divisor {high, low} |

## Verification
The assertions assume that we_i and re_i are never high together. They also assume that latch_sel_i and addr_i hold steady for the whole cycle in which a strobe is high, as they would if driven by a single bus master. The bench drives one access per cycle. It changes the address, the select bit and the strobes only on the falling edge, and it drops each strobe after exactly one rising edge, so every access falls inside these assumptions.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MIN_DIV = 2;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_LATCH,
    ACC_DATA
  } acc_kind_e;
endpackage

// File: rtl/baud_addr_dec.sv
module baud_addr_dec
  import baud_gen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned NBYTES  = 2,
  parameter int unsigned LO_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              latch_sel_i,
  output logic [NBYTES-1:0] lane_hit_o,
  output logic              data_hit_o,
  output acc_kind_e         kind_o
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign lane_hit_o[k] = latch_sel_i && (addr_i == ADDR_W'(LO_ADDR + k));
  end

  assign data_hit_o = !latch_sel_i && (addr_i == ADDR_W'(LO_ADDR));

  always_comb begin
    if (|lane_hit_o)     kind_o = ACC_LATCH;
    else if (data_hit_o) kind_o = ACC_DATA;
    else                 kind_o = ACC_NONE;
  end

  // shared address never reaches both targets at once
  assert_one_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lane_hit_o, data_hit_o}));
endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_gen_pkg::*;
#(
  parameter int unsigned NBYTES  = 2,
  parameter int unsigned RST_DIV = 2,
  localparam int unsigned DIV_W  = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBYTES-1:0] lane_hit_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [DIV_W-1:0]  div_next_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  logic [DIV_W-1:0] div_q;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign div_next_o[k*BYTE_W +: BYTE_W] =
      (we_i && lane_hit_i[k]) ? wdata_i : div_q[k*BYTE_W +: BYTE_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  div_q[k*BYTE_W +: BYTE_W] <= BYTE_W'(RST_DIV >> (k*BYTE_W));
      else if (we_i && lane_hit_i[k]) div_q[k*BYTE_W +: BYTE_W] <= wdata_i;
    end

    assert_lane_wr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && lane_hit_i[k]) |=> div_q[k*BYTE_W +: BYTE_W] == $past(wdata_i));
  end

  assign load_o = we_i && (|lane_hit_i);
  assign div_o  = div_q;

  always_comb begin
    rd_byte_o = '0;
    for (int k = 0; k < NBYTES; k++)
      if (re_i && lane_hit_i[k]) rd_byte_o = div_q[k*BYTE_W +: BYTE_W];
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(div_q));
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
  import baud_gen_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned RST_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] v);
    return (v < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= eff_div(DIV_W'(RST_DIV));
    else if (load_i)                 cnt_q <= eff_div(load_val_i);
    else if (cnt_q == DIV_W'(1))     cnt_q <= eff_div(div_i);
    else                             cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = (cnt_q == DIV_W'(1));

  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !tick_o);
  assert_single_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_cnt_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned LO_ADDR = 0,
  parameter int unsigned RST_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              latch_sel_i,
  input  logic [7:0]        data_rdata_i,
  output logic [7:0]        rdata_o,
  output logic              data_we_o,
  output logic              data_re_o,
  output logic              tick_o,
  output logic [DIV_W-1:0]  divisor_o
);
  localparam int unsigned NBYTES = DIV_W / BYTE_W;

  logic [NBYTES-1:0] lane_hit;
  logic              data_hit;
  acc_kind_e         kind;
  logic [DIV_W-1:0]  div_next;
  logic              load;
  logic [7:0]        rd_byte;

  baud_addr_dec #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .LO_ADDR(LO_ADDR)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .latch_sel_i(latch_sel_i),
    .lane_hit_o(lane_hit), .data_hit_o(data_hit), .kind_o(kind)
  );

  baud_div_regs #(.NBYTES(NBYTES), .RST_DIV(RST_DIV)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_hit_i(lane_hit), .we_i(we_i), .re_i(re_i),
    .wdata_i(wdata_i), .div_o(divisor_o), .div_next_o(div_next), .load_o(load),
    .rd_byte_o(rd_byte)
  );

  baud_div_counter #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(div_next),
    .div_i(divisor_o), .tick_o(tick_o)
  );

  assign data_we_o = we_i && data_hit;
  assign data_re_o = re_i && data_hit;

  always_comb begin
    unique case (kind)
      ACC_LATCH: rdata_o = rd_byte;
      ACC_DATA:  rdata_o = re_i ? data_rdata_i : 8'h00;
      default:   rdata_o = 8'h00;
    endcase
  end

  assert_data_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |=> $stable(divisor_o));
  assert_strobe_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_o || data_re_o) |-> !latch_sel_i);
endmodule

// File: tb/baud_rate_gen_bench.sv
module baud_rate_gen_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, data_rd = 8'hA5;
  logic we = 0, re = 0, sel = 0;
  logic [7:0] rdata;
  logic data_we, data_re, tick;
  logic [15:0] divisor;

  int cyc = 0, checks = 0, errors = 0;
  bit mon_on = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  baud_rate_gen u_baud_rate_gen (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .latch_sel_i(sel), .data_rdata_i(data_rd), .rdata_o(rdata), .data_we_o(data_we),
    .data_re_o(data_re), .tick_o(tick), .divisor_o(divisor)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected tick cycle and compare
  always @(negedge clk) begin
    if (mon_on && tick) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected tick", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R3/R4 tick timing", cyc, e);
      end
    end
  end

  always @(posedge clk) if (cyc > 190000) begin
    chk(0, "watchdog", cyc, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic s);
    @(negedge clk);
    addr = a; wdata = d; sel = s; we = 1;
    @(posedge clk);
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic s, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; sel = s; re = 1;
    #1 chk(rdata == exp, req, rdata, exp);
    @(negedge clk);
    re = 0;
  endtask

  // driver: call right after wr(); expects ticks N, 2N, ... cycles after the write edge
  task automatic expect_ticks(input int n, input int k, input string req);
    int c0;
    c0 = cyc;
    exp_q.delete();
    for (int i = 1; i <= k; i++) exp_q.push_back(c0 + i*n - 1);
    mon_on = 1;
    repeat (k*n) @(negedge clk);
    mon_on = 0;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(divisor == 16'h0002, "R2 reset divisor", divisor, 2);
    chk(rdata == 8'h00 && tick == 0, "R7 reset outputs", rdata, 0);
    rst_n = 1;
    begin
      int r;
      r = cyc;
      for (int i = 0; i < 4; i++) exp_q.push_back(r + 1 + 2*i);
      mon_on = 1;
      repeat (8) @(negedge clk);
      mon_on = 0;
      chk(exp_q.size() == 0, "R2 reset period", exp_q.size(), 0);
    end

    // R1 / R3: divisor 5
    wr(3'd1, 8'h00, 1);
    wr(3'd0, 8'h05, 1);
    chk(divisor == 16'h0005, "R1 divisor", divisor, 5);
    expect_ticks(5, 4, "R3 div5 missing ticks");
    rd(3'd0, 1, 8'h05, "R1 read low");
    rd(3'd1, 1, 8'h00, "R1 read high");

    // R4: high-byte write restarts, N = 0x0105
    wr(3'd1, 8'h01, 1);
    chk(divisor == 16'h0105, "R1 divisor high", divisor, 16'h0105);
    expect_ticks(16'h0105, 3, "R4 high write restart");
    rd(3'd1, 1, 8'h01, "R1 read high");

    // R4: mid-count restart with same value
    wr(3'd1, 8'h00, 1);
    wr(3'd0, 8'h07, 1);
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h07, 1);
    expect_ticks(7, 3, "R4 mid-count restart");

    // R5: clamp
    wr(3'd0, 8'h00, 1);
    chk(divisor == 16'h0000, "R5 readback zero", divisor, 0);
    expect_ticks(2, 5, "R5 div0 period");
    wr(3'd0, 8'h01, 1);
    chk(divisor == 16'h0001, "R5 readback one", divisor, 1);
    expect_ticks(2, 5, "R5 div1 period");

    // R6: data path steering
    @(negedge clk);
    addr = 3'd0; sel = 0; wdata = 8'h3C; we = 1;
    #1 chk(data_we == 1, "R6 data write strobe", data_we, 1);
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk(divisor == 16'h0001, "R6 latch untouched", divisor, 1);
    rd(3'd0, 0, 8'hA5, "R6 data read");
    @(negedge clk);
    addr = 3'd0; sel = 0; re = 1;
    #1 chk(data_re == 1, "R6 data read strobe", data_re, 1);
    @(negedge clk);
    re = 0;

    // R7: ignored accesses
    @(negedge clk);
    addr = 3'd1; sel = 0; wdata = 8'hEE; we = 1;
    #1 chk(data_we == 0, "R7 no strobe at high addr", data_we, 0);
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk(divisor == 16'h0001, "R7 high addr ignored", divisor, 1);
    wr(3'd5, 8'h77, 1);
    chk(divisor == 16'h0001, "R7 other addr ignored", divisor, 1);
    rd(3'd1, 0, 8'h00, "R7 read high gated");
    rd(3'd5, 1, 8'h00, "R7 read other addr");

    // R3: larger divisor
    wr(3'd0, 8'h00, 1);
    wr(3'd1, 8'h03, 1);
    chk(divisor == 16'h0300, "R1 divisor 0x300", divisor, 16'h0300);
    expect_ticks(16'h0300, 2, "R3 div 0x300");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule